// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This controller gathers 32 interrupt inputs and presents one interrupt request to a processor. Software gives each input a priority from 0 to 7, a trigger kind (active-high level, active-low level, rising edge or falling edge) and a 32-bit vector word. It also has an enable mask and a pending set with command registers that set and clear them. Software drives all of this through a simple 32-bit register bus.

A handler reads the vector register. That read returns the vector word of the best pending, enabled input. The read also acknowledges that input: it records the source number and pushes the source's priority onto an 8-entry nesting stack. While the stack holds a level, only an input of strictly higher priority can raise the request line again. Any write to the end-of-interrupt register pops one level. When nothing qualifies, the vector read returns a software-chosen spurious word and changes no state.

Register bus: `bus_addr` is a byte address. Reads are registered, so `bus_rdata` holds the value one clock after `bus_rd`. Offsets: mode of source n at n*4, vector of source n at 0x80+n*4, vector/acknowledge 0x100, current source 0x108, pending 0x10C, enable mask 0x110, line status 0x114, enable command 0x120, disable command 0x124, pending clear 0x128, pending set 0x12C, end of interrupt 0x130, spurious word 0x134.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the mask, pending, current-source registers and every vector word read zero, and `irq_o` is low.
- R2: A mode register keeps priority in bits [2:0] and trigger kind in bits [6:5] and reads other bits as zero. Vector words and the spurious word read back exactly as written.
- R3: Writing the enable command sets the mask bits written as 1. Writing the disable command clears them. Bits written as 0 leave the mask unchanged.
- R4: Writing the pending set command makes the sources written as 1 pending. Writing the pending clear command removes that latched pending state. Bits written as 0 have no effect.
- R5: Trigger kinds are encoded 0 = active-high level, 1 = active-low level, 2 = rising edge, 3 = falling edge. A level source is pending while its synchronised input is active. An edge source latches pending on the active edge and stays pending after the input returns.
- R6: A vector read returns the vector word of the enabled, pending source with the highest priority above the stack top. Equal priorities go to the lower source number. The current-source register then shows that number.
- R7: Acknowledging an edge source clears its pending bit. A level source stays pending while its input is active.
- R8: `irq_o` is high exactly when some enabled, pending source has a priority greater than the stack top, or any priority when the stack is empty.
- R9: An end-of-interrupt write pops one level, and the current-source register then shows the outer source. Writes to an empty stack are ignored. Eight nested acknowledges followed by eight end-of-interrupt writes leave the controller idle and able to request again.
- R10: A vector read with no qualifying source returns the spurious word and pushes nothing. The current-source register reads zero while the stack is empty.
- R11: Bit 0 of the line status register reflects `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt inputs, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted stack top appears at `irq_o` in the same cycle. The line either stays low for a source that should pre-empt, or rises for one that should be held back. The next vector read then returns the wrong word. A lost push or pop appears at the next end-of-interrupt write, because the current-source register then names the wrong outer source. A stray pending bit appears on the first pending read, one cycle after the read strobe.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC  = 32,
  parameter int PW    = 3,
  parameter int DEPTH = 8,
  parameter int AW    = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o
);
  localparam int SW = $clog2(NSRC);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_VEC  = AW'('h100);
  localparam logic [AW-1:0] A_CUR  = AW'('h108);
  localparam logic [AW-1:0] A_PEND = AW'('h10C);
  localparam logic [AW-1:0] A_MASK = AW'('h110);
  localparam logic [AW-1:0] A_LINE = AW'('h114);
  localparam logic [AW-1:0] A_EN   = AW'('h120);
  localparam logic [AW-1:0] A_DIS  = AW'('h124);
  localparam logic [AW-1:0] A_CLR  = AW'('h128);
  localparam logic [AW-1:0] A_SET  = AW'('h12C);
  localparam logic [AW-1:0] A_EOI  = AW'('h130);
  localparam logic [AW-1:0] A_SPUR = AW'('h134);

  logic [PW-1:0]   prio_q [NSRC];
  logic [1:0]      trig_q [NSRC];
  logic [31:0]     vect_q [NSRC];
  logic [31:0]     spur_q;
  logic [NSRC-1:0] mask_q, latch_q, s1_q, s2_q, s3_q;
  logic [SW-1:0]   stk_s [DEPTH];
  logic [PW-1:0]   stk_p [DEPTH];
  logic [CW-1:0]   depth_q;

  logic [NSRC-1:0] lvl_v, edge_v, pend_v, elig_v, ack_clr;
  logic            best_any;
  logic [PW-1:0]   best_p;
  logic [SW-1:0]   best_src;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      logic act, prev;
      assign act       = s2_q[g] ^ trig_q[g][0];
      assign prev      = s3_q[g] ^ trig_q[g][0];
      assign lvl_v[g]  = ~trig_q[g][1] & act;
      assign edge_v[g] = trig_q[g][1] & act & ~prev;
    end
  endgenerate

  assign pend_v = latch_q | lvl_v;
  assign elig_v = pend_v & mask_q;

  always_comb begin
    best_any = 1'b0;
    best_p   = '0;
    best_src = '0;
    for (int n = NSRC - 1; n >= 0; n--)
      if (elig_v[n] && (!best_any || prio_q[n] >= best_p)) begin
        best_any = 1'b1;
        best_p   = prio_q[n];
        best_src = SW'(n);
      end
  end

  assign irq_o = best_any && (depth_q == '0 || best_p > stk_p[0]);

  logic in_mode, in_vect, ack, push, pop;
  logic [SW-1:0] ridx;
  assign in_mode = bus_addr[AW-1:SW+2] == '0;
  assign in_vect = bus_addr[AW-1:SW+2] == (AW-SW-2)'(1);
  assign ridx    = bus_addr[SW+1:2];
  assign ack     = bus_rd && bus_addr == A_VEC;
  assign push    = ack && irq_o;
  assign pop     = bus_wr && bus_addr == A_EOI && depth_q != '0 && !push;
  assign ack_clr = (push && trig_q[best_src][1]) ? (NSRC'(1) << best_src) : '0;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_mode)      rd_mux = (32'(trig_q[ridx]) << 5) | 32'(prio_q[ridx]);
    else if (in_vect) rd_mux = vect_q[ridx];
    else case (bus_addr)
      A_VEC:  rd_mux = irq_o ? vect_q[best_src] : spur_q;
      A_CUR:  rd_mux = (depth_q != '0) ? 32'(stk_s[0]) : '0;
      A_PEND: rd_mux = 32'(pend_v);
      A_MASK: rd_mux = 32'(mask_q);
      A_LINE: rd_mux = {31'b0, irq_o};
      A_SPUR: rd_mux = spur_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
      bus_rdata <= '0;
    end else begin
      s1_q <= src_i; s2_q <= s1_q; s3_q <= s2_q;
      if (bus_rd) bus_rdata <= rd_mux;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int n = 0; n < NSRC; n++) begin
        prio_q[n] <= '0; trig_q[n] <= '0; vect_q[n] <= '0;
      end
      spur_q  <= '0;
      mask_q  <= '0;
      latch_q <= '0;
    end else begin
      latch_q <= (latch_q | edge_v | ((bus_wr && bus_addr == A_SET) ? bus_wdata[NSRC-1:0] : '0))
               & ~(((bus_wr && bus_addr == A_CLR) ? bus_wdata[NSRC-1:0] : '0) | ack_clr);
      if (bus_wr) begin
        if (in_mode) begin
          prio_q[ridx] <= bus_wdata[PW-1:0];
          trig_q[ridx] <= bus_wdata[6:5];
        end else if (in_vect) vect_q[ridx] <= bus_wdata;
        else case (bus_addr)
          A_EN:   mask_q <= mask_q | bus_wdata[NSRC-1:0];
          A_DIS:  mask_q <= mask_q & ~bus_wdata[NSRC-1:0];
          A_SPUR: spur_q <= bus_wdata;
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stk_s[i] <= '0; stk_p[i] <= '0;
      end
    end else if (push) begin
      depth_q  <= depth_q + 1'b1;
      stk_s[0] <= best_src;
      stk_p[0] <= best_p;
      for (int i = 1; i < DEPTH; i++) begin
        stk_s[i] <= stk_s[i-1]; stk_p[i] <= stk_p[i-1];
      end
    end else if (pop) begin
      depth_q <= depth_q - 1'b1;
      for (int i = 0; i < DEPTH - 1; i++) begin
        stk_s[i] <= stk_s[i+1]; stk_p[i] <= stk_p[i+1];
      end
    end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NSRC  = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 9,
  parameter int CW    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_o,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic [CW-1:0]   depth,
  input logic [NSRC-1:0] mask,
  input logic [31:0]     spur
);
  localparam logic [AW-1:0] A_VEC = AW'('h100);
  localparam logic [AW-1:0] A_EN  = AW'('h120);
  localparam logic [AW-1:0] A_EOI = AW'('h130);

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));

  p_ack_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_VEC && irq_o) |=> depth == $past(depth) + 1'b1);

  p_spur_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_VEC && !irq_o && !bus_wr)
      |=> (bus_rdata == $past(spur) && depth == $past(depth)));

  p_eoi_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EOI && !(bus_rd && bus_addr == A_VEC))
      |=> depth == (($past(depth) == '0) ? '0 : $past(depth) - 1'b1));

  p_enable_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EN)
      |=> (mask & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]));

  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NSRC(NSRC), .DEPTH(DEPTH), .AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .depth(depth_q), .mask(mask_q), .spur(spur_q));

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  vec_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; src_i = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic int winner(input logic [31:0] elig, input logic [2:0] pr [32]);
    int w = -1;
    for (int n = 0; n < 32; n++)
      if (elig[n] && (w < 0 || pr[n] > pr[w])) w = n;
    return w;
  endfunction

  logic [31:0] v;
  logic [2:0]  pr [32];
  logic [31:0] vv [32];

  initial begin
    #600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    do_reset();
    // R1 reset state
    rd(9'h110, v); chk("R1 mask", v, 0);
    rd(9'h10C, v); chk("R1 pend", v, 0);
    rd(9'h108, v); chk("R1 cur", v, 0);
    rd(9'h094, v); chk("R1 vec5", v, 0);
    chk("R1 irq", 32'(irq_o), 0);

    // R2 readback
    wr(9'h00C, 32'hFFFF_FFFF); rd(9'h00C, v); chk("R2 mode", v, 32'h67);
    wr(9'h08C, 32'hDEAD_BEEF); rd(9'h08C, v); chk("R2 vec", v, 32'hDEAD_BEEF);
    wr(9'h134, 32'h1234_5678); rd(9'h134, v); chk("R2 spur", v, 32'h1234_5678);

    // R3 enable / disable
    wr(9'h120, 32'hF0); rd(9'h110, v); chk("R3 en", v, 32'hF0);
    wr(9'h120, 32'h0);  rd(9'h110, v); chk("R3 en zero", v, 32'hF0);
    wr(9'h124, 32'h30); rd(9'h110, v); chk("R3 dis", v, 32'hC0);
    wr(9'h124, 32'h0);  rd(9'h110, v); chk("R3 dis zero", v, 32'hC0);

    // R4 software set / clear
    do_reset();
    wr(9'h010, 32'h40);
    wr(9'h12C, 32'h30); rd(9'h10C, v); chk("R4 set", v, 32'h30);
    wr(9'h12C, 32'h0);  rd(9'h10C, v); chk("R4 set zero", v, 32'h30);
    wr(9'h128, 32'h0);  rd(9'h10C, v); chk("R4 clr zero", v, 32'h30);
    wr(9'h128, 32'h30); rd(9'h10C, v); chk("R4 clr", v, 32'h0);

    // R5 trigger kinds
    do_reset();
    wr(9'h004, 32'h20); wr(9'h008, 32'h40); wr(9'h018, 32'h60);
    settle(); rd(9'h10C, v); chk("R5 low level", v, 32'h02);
    src_i[2] = 1'b1; settle(); rd(9'h10C, v); chk("R5 rise", v, 32'h06);
    src_i[2] = 1'b0; settle(); rd(9'h10C, v); chk("R5 rise held", v, 32'h06);
    src_i[6] = 1'b1; settle(); rd(9'h10C, v); chk("R5 fall none", v, 32'h06);
    src_i[6] = 1'b0; settle(); rd(9'h10C, v); chk("R5 fall", v, 32'h46);
    src_i[1] = 1'b1; settle(); rd(9'h10C, v); chk("R5 low off", v, 32'h44);

    // R6 R7 R8 R9 R11 nesting
    do_reset();
    wr(9'h028, 32'h42); wr(9'h02C, 32'h02); wr(9'h050, 32'h05);
    wr(9'h0A8, 32'h100A); wr(9'h0AC, 32'h100B); wr(9'h0D0, 32'h1014);
    wr(9'h120, 32'h0010_0C00);
    src_i[10] = 1'b1; src_i[11] = 1'b1; settle();
    chk("R8 irq idle", 32'(irq_o), 1);
    rd(9'h114, v); chk("R11 line hi", v, 1);
    rd(9'h100, v); chk("R6 tie vec", v, 32'h100A);
    rd(9'h108, v); chk("R6 cur", v, 10);
    rd(9'h10C, v); chk("R7 edge clr", v, 32'h800);
    chk("R8 equal held", 32'(irq_o), 0);
    rd(9'h114, v); chk("R11 line lo", v, 0);
    src_i[20] = 1'b1; settle();
    chk("R8 preempt", 32'(irq_o), 1);
    rd(9'h100, v); chk("R6 nested vec", v, 32'h1014);
    rd(9'h108, v); chk("R6 nested cur", v, 20);
    chk("R8 top held", 32'(irq_o), 0);
    wr(9'h130, 0); rd(9'h108, v); chk("R9 pop cur", v, 10);
    chk("R8 after pop", 32'(irq_o), 1);
    src_i[20] = 1'b0; settle(); chk("R8 drop", 32'(irq_o), 0);
    wr(9'h130, 0); rd(9'h108, v); chk("R9 empty cur", v, 0);
    chk("R8 empty irq", 32'(irq_o), 1);
    wr(9'h130, 0); rd(9'h108, v); chk("R9 extra eoi", v, 0);
    rd(9'h100, v); chk("R9 after extra", v, 32'h100B);
    rd(9'h108, v); chk("R9 cur11", v, 11);
    wr(9'h130, 0); rd(9'h108, v); chk("R9 final", v, 0);

    // R10 spurious
    do_reset();
    wr(9'h134, 32'h0000_ABCD); src_i[0] = 1'b1; settle();
    rd(9'h100, v); chk("R10 spur", v, 32'h0000_ABCD);
    rd(9'h108, v); chk("R10 cur", v, 0);

    // R9 eight-deep nesting
    do_reset();
    for (int p = 0; p < 8; p++) begin
      wr(9'(p * 4), 32'(p)); wr(9'(9'h080 + p * 4), 32'(32'h200 + p));
    end
    src_i = 32'hFF; settle();
    for (int p = 0; p < 8; p++) begin
      wr(9'h120, 32'(1) << p);
      rd(9'h100, v); chk("R9 deep ack", v, 32'(32'h200 + p));
    end
    chk("R9 full irq", 32'(irq_o), 0);
    for (int k = 0; k < 8; k++) begin
      wr(9'h130, 0); rd(9'h108, v); chk("R9 unwind", v, (k < 7) ? 32'(6 - k) : 32'd0);
    end
    chk("R9 unlocked", 32'(irq_o), 1);
    src_i = '0; settle(); chk("R9 quiet", 32'(irq_o), 0);

    // R6 R8 random level scenarios
    for (int it = 0; it < 12; it++) begin
      logic [31:0] m, sp;
      int w;
      do_reset();
      for (int n = 0; n < 32; n++) begin
        pr[n] = 3'($urandom);
        vv[n] = $urandom;
        wr(9'(n * 4), 32'(pr[n]));
        wr(9'(9'h080 + n * 4), vv[n]);
      end
      m  = $urandom & $urandom;
      sp = $urandom;
      wr(9'h120, m); wr(9'h134, sp);
      src_i = $urandom & $urandom & $urandom;
      settle();
      w = winner(src_i & m, pr);
      chk("R8 rand irq", 32'(irq_o), (w >= 0) ? 1 : 0);
      rd(9'h100, v); chk("R6 rand vec", v, (w >= 0) ? vv[w] : sp);
      rd(9'h108, v); chk("R6 rand cur", v, (w >= 0) ? 32'(w) : 32'd0);
      chk("R8 rand held", 32'(irq_o), 0);
      wr(9'h130, 0); rd(9'h108, v); chk("R9 rand pop", v, 0);
      chk("R8 rand again", 32'(irq_o), (w >= 0) ? 1 : 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule